// File: doc/BRIEF.md
# DS3 Path-Parity Error Monitor

This block watches the per-frame results of a DS3 C-bit parity receiver and counts the frames whose path-parity (CP) bits were found wrong. The frame decoder gives a frame strobe and an error flag on the same cycle. Each frame with wrong parity adds exactly one to the count, however many parity bits in it were bad. Two 16-bit counts exist. The live count clears when software reads it. The one-second snapshot is loaded from a per-second tally each time the one-second tick arrives. Software reads both counts one byte at a time through an 8-bit read port with a two-bit register select.

The same per-frame result is turned back towards the local transmitter at once. When a frame with bad parity arrives, the block raises an error request for that frame and offers a three-bit far-end block error code of 000. Otherwise the request is low and the code is 111, the no-error value.

The frame result input is a qualified pulse, not a handshaked stream. The block accepts a result on every cycle, so it never applies back-pressure, and the decoder needs no ready signal. The read port has no wait states: `rd_data` shows the selected byte in the same cycle, and a read's side effects happen at the clock edge that ends a cycle with `rd_en` high.

Top module: `cpmon_top`

## Requirements
- R1: On each clock edge where `frm_strobe` and `cp_err` are both 1, the live count rises by one. A cycle with `frm_strobe` low leaves every count unchanged, whatever `cp_err` is.
- R2: `rd_sel` picks the byte shown on `rd_data`: 0 is live bits 15:8, 1 is live bits 7:0, 2 is snapshot bits 15:8, and 3 is snapshot bits 7:0.
- R3: A read with `rd_en`=1 and `rd_sel`=1 clears the live count at that edge. All counts are zero after reset.
- R4: A read of select 0 stores the whole live value in a hold register. The next read of select 1 returns the stored low byte, not the current one. That read then leaves in the live count only the errors that came after the select-0 read.
- R5: If an erred frame lands on the same edge as a clearing select-1 read (with no hold pending), the live count ends at 1.
- R6: The live count, the per-second tally and the snapshot all stop at 0xFFFF and do not wrap.
- R7: On a `sec_tick` edge, the snapshot takes the tally of the second just ending, including an erred frame on that same edge. The tally for the new second starts from zero.
- R8: Reading the snapshot (select 2 or 3) never changes it. It changes only on `sec_tick`.
- R9: In a cycle where `frm_strobe` and `cp_err` are both 1, `febe_err` is 1 and `febe_code` is 000. In every other cycle, `febe_err` is 0 and `febe_code` is 111.
- R10: Right after reset, all four readable bytes are 0x00 and `febe_code` is 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_strobe | input | 1 | One cycle per received frame |
| cp_err | input | 1 | Path parity of the strobed frame was wrong |
| sec_tick | input | 1 | One-second boundary pulse |
| rd_en | input | 1 | Read strobe; side effects at the edge |
| rd_sel | input | 2 | Byte select (see R2) |
| rd_data | output | 8 | Selected byte |
| febe_err | output | 1 | Error request to transmitter, same cycle as the frame |
| febe_code | output | 3 | Far-end block error code to send |

## Verification
Two cases are the hardest to bring about from the ports. The first is saturation: every count must pass 0xFFFF, which takes more than 65535 erred frames with no clearing read and no tick in between. The stimulus makes this one uninterrupted burst and then checks the live bytes and, after a single tick, the snapshot. The second is the split 16-bit read: an error must arrive between the select-0 and select-1 reads to show that the hold register keeps the two bytes consistent without losing that error. The bench builds the live count to 0x00FF, reads the high byte, injects one frame, and then reads the low byte. A final case lands a clearing read and an erred frame on the same edge.

// File: rtl/cpmon_pkg.sv
package cpmon_pkg;
  localparam int FEBE_W = 3;
  localparam logic [FEBE_W-1:0] FEBE_CLEAN = 3'b111;
  localparam logic [FEBE_W-1:0] FEBE_BAD   = 3'b000;

  typedef enum logic [1:0] {
    SEL_LIVE_HI = 2'd0,
    SEL_LIVE_LO = 2'd1,
    SEL_SNAP_HI = 2'd2,
    SEL_SNAP_LO = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/cpmon_pair_rd.sv
// Byte-pair read helper: a high-byte read freezes the full value so the
// following low-byte read returns the matching half.
module cpmon_pair_rd #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  val,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte,
  output logic              hold_armed,
  output logic [CNT_W-1:0]  hold_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_armed <= 1'b0;
      hold_val   <= '0;
    end else if (rd_hi) begin
      hold_armed <= 1'b1;
      hold_val   <= val;
    end else if (rd_lo) begin
      hold_armed <= 1'b0;
    end
  end

  assign hi_byte = val[CNT_W-1:BYTE_W];
  assign lo_byte = hold_armed ? hold_val[BYTE_W-1:0] : val[BYTE_W-1:0];

  // R4: a high-byte read arms the hold with the value seen at that edge
  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (hold_armed && hold_val == $past(val)));
  // R4: a low-byte read (without a high read) releases the hold
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> !hold_armed);
endmodule

// File: rtl/cpmon_live_ctr.sv
// Reset-on-read live error counter with saturation and split-read credit.
module cpmon_live_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_clr,
  input  logic             hold_armed,
  input  logic [CNT_W-1:0] hold_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, base, nxt;

  always_comb begin
    base = cnt_q;
    if (rd_clr) base = hold_armed ? (cnt_q - hold_val) : '0;
    nxt = (inc && base != MAXV) ? base + CNT_W'(1) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign cnt = cnt_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_clr && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !rd_clr) |=> $stable(cnt_q));
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !rd_clr) |=> cnt_q == MAXV);
  p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hold_armed && inc) |=> cnt_q == CNT_W'(1));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hold_armed && !inc) |=> cnt_q == '0);
endmodule

// File: rtl/cpmon_sec_acc.sv
// Per-second tally and one-second snapshot.
module cpmon_sec_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             tick,
  output logic [CNT_W-1:0] snap
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] tally_q, snap_q, tally_sum;

  assign tally_sum = (inc && tally_q != MAXV) ? tally_q + CNT_W'(1) : tally_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_q <= '0;
      snap_q  <= '0;
    end else if (tick) begin
      tally_q <= '0;
      snap_q  <= tally_sum;
    end else begin
      tally_q <= tally_sum;
    end
  end

  assign snap = snap_q;

  p_new_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tally_q == '0);
  p_snap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !inc) |=> snap_q == $past(tally_q));
  p_snap_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(snap_q));
  p_tally_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tally_q == MAXV && !tick) |=> tally_q == MAXV);
endmodule

// File: rtl/cpmon_top.sv
module cpmon_top
  import cpmon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_strobe,
  input  logic              cp_err,
  input  logic              sec_tick,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              febe_err,
  output logic [FEBE_W-1:0] febe_code
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NPAIR  = 2;

  logic             bad_frame;
  logic [CNT_W-1:0] live_cnt, snap_cnt;

  logic [CNT_W-1:0]  pair_val   [NPAIR];
  logic [BYTE_W-1:0] pair_hi    [NPAIR];
  logic [BYTE_W-1:0] pair_lo    [NPAIR];
  logic              pair_armed [NPAIR];
  logic [CNT_W-1:0]  pair_hold  [NPAIR];

  assign bad_frame = frm_strobe & cp_err;

  assign febe_err  = bad_frame;
  assign febe_code = bad_frame ? FEBE_BAD : FEBE_CLEAN;

  assign pair_val[0] = live_cnt;
  assign pair_val[1] = snap_cnt;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    cpmon_pair_rd #(.BYTE_W(BYTE_W)) i_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .val        (pair_val[g]),
      .rd_hi      (rd_en && rd_sel[1] == g[0] && !rd_sel[0]),
      .rd_lo      (rd_en && rd_sel[1] == g[0] &&  rd_sel[0]),
      .hi_byte    (pair_hi[g]),
      .lo_byte    (pair_lo[g]),
      .hold_armed (pair_armed[g]),
      .hold_val   (pair_hold[g])
    );
  end

  cpmon_live_ctr #(.CNT_W(CNT_W)) i_live (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (bad_frame),
    .rd_clr     (rd_en && rd_sel == SEL_LIVE_LO),
    .hold_armed (pair_armed[0]),
    .hold_val   (pair_hold[0]),
    .cnt        (live_cnt)
  );

  cpmon_sec_acc #(.CNT_W(CNT_W)) i_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bad_frame),
    .tick  (sec_tick),
    .snap  (snap_cnt)
  );

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      SEL_LIVE_HI: rd_data = pair_hi[0];
      SEL_LIVE_LO: rd_data = pair_lo[0];
      SEL_SNAP_HI: rd_data = pair_hi[1];
      SEL_SNAP_LO: rd_data = pair_lo[1];
      default:     rd_data = '0;
    endcase
  end

  p_febe_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_strobe && cp_err) |-> (febe_err && febe_code != FEBE_CLEAN));
  p_febe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_strobe && cp_err) |-> (!febe_err && febe_code == FEBE_CLEAN));
  p_snap_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel[1] && !sec_tick) |=> $stable(snap_cnt));
endmodule

// File: tb/test_cpmon_top.sv
module test_cpmon_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {strobe, err, tick, expected febe_code[2:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110_000, 6'b100_111, 6'b010_111, 6'b110_000, 6'b111_000,
    6'b110_000, 6'b000_111, 6'b101_111, 6'b110_000, 6'b000_111
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_strobe = 1'b0, cp_err = 1'b0, sec_tick = 1'b0, rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       febe_err;
  logic [2:0] febe_code;

  int total = 0, failed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpmon_top i_cpmon_top (
    .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .cp_err(cp_err),
    .sec_tick(sec_tick), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .febe_err(febe_err), .febe_code(febe_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; combinational outputs sampled mid-cycle
  task automatic cyc(input logic s, input logic e, input logic t,
                     input logic re, input logic [1:0] sel,
                     output logic [7:0] d, output logic [2:0] fc, output logic fe);
    @(negedge clk);
    frm_strobe = s; cp_err = e; sec_tick = t; rd_en = re; rd_sel = sel;
    #1;
    d = rd_data; fc = febe_code; fe = febe_err;
    @(posedge clk);
    #1;
    frm_strobe = 1'b0; cp_err = 1'b0; sec_tick = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] sel, output logic [7:0] d);
    logic [2:0] fc; logic fe;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, sel, d, fc, fe);
  endtask

  task automatic rd16(input logic [1:0] base, output logic [15:0] v);
    logic [7:0] hi, lo;
    rd_byte(base, hi);
    rd_byte(base | 2'd1, lo);
    v = {hi, lo};
  endtask

  task automatic frames(input int n);
    logic [7:0] d; logic [2:0] fc; logic fe;
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, d, fc, fe);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic [2:0] fc; logic fe; logic [15:0] v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    #1 chk("R10 febe_code after reset", febe_code, 3'b111);
    rd_byte(2'd2, d); chk("R10 snapshot hi after reset", d, 8'h00);
    rd_byte(2'd3, d); chk("R10 snapshot lo after reset", d, 8'h00);
    rd16(2'd0, v);    chk("R3 R10 live after reset", v, 16'h0000);

    // vector table: FEBE per frame (R9), counting incl. ignored strobe-low (R1), tick (R7)
    for (int k = 0; k < NVEC; k++) begin
      cyc(VEC[k][5], VEC[k][4], VEC[k][3], 1'b0, 2'd0, d, fc, fe);
      chk($sformatf("R9 febe_code vec %0d", k), fc, VEC[k][2:0]);
      chk($sformatf("R9 febe_err vec %0d", k), fe, (VEC[k][2:0] == 3'b000));
    end
    rd16(2'd0, v);  chk("R1 R2 live count after table", v, 16'd5);
    rd16(2'd2, v);  chk("R7 R2 snapshot after second tick", v, 16'd1);
    rd16(2'd0, v);  chk("R3 live cleared by low read", v, 16'd0);
    rd16(2'd2, v2); chk("R8 snapshot unchanged by reads", v2, 16'd1);

    // R4 split read keeps bytes coherent and keeps the in-between error
    frames(255);
    rd_byte(2'd0, d); chk("R4 live hi at 0x00FF", d, 8'h00);
    frames(1);
    rd_byte(2'd1, d); chk("R4 held low byte", d, 8'hFF);
    rd16(2'd0, v);    chk("R4 error after hi read retained", v, 16'd1);

    // R5 error on the clearing edge
    frames(3);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, d, fc, fe);
    chk("R5 low byte on collision read", d, 8'h03);
    rd16(2'd0, v);    chk("R5 count after collision", v, 16'd1);

    // R6 saturation of live, tally and snapshot
    frames(65540);
    rd16(2'd0, v);    chk("R6 live saturates", v, 16'hFFFF);
    rd16(2'd2, v);    chk("R8 snapshot still old before tick", v, 16'd1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, d, fc, fe);
    rd16(2'd2, v);    chk("R6 R7 snapshot saturates", v, 16'hFFFF);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, d, fc, fe);
    rd16(2'd2, v);    chk("R7 new second starts at zero", v, 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule